// File: doc/BRIEF.md
# Complementary Output Dead-Time Generator

This block turns one reference PWM waveform into a complementary pair of drive outputs: a true output that is active while the reference is high and a complementary output that is active while it is low. Each change of the reference turns off the output that was active at once. The opposite output is held off for a programmable dead time, so the two outputs are never active together. The dead time is counted in ticks of a dead-time clock enable. Its length comes from an 8-bit code through a four-range piecewise encoding, which gives fine steps for short gaps and coarse steps for long ones.

Polarity is applied after the dead time is inserted. A main output enable and an idle off-state select decide what the pins and their enable signals do when the drive stage is switched off. It is used between a PWM compare unit and the gate drivers of a half bridge.

Top module: `cdt_pair`

## Requirements
- R1: When code bit 7 is 0, the dead time is the whole 8-bit code value in ticks (0x00 gives 0, 0x7F gives 127).
- R2: When code bits 7:5 are 10x, the dead time is (64 + code bits 5:0) x 2 ticks (0x80 gives 128, 0xBF gives 254).
- R3: When code bits 7:5 are 110, the dead time is (32 + code bits 4:0) x 8 ticks (0xC0 gives 256, 0xDF gives 504).
- R4: When code bits 7:5 are 111, the dead time is (32 + code bits 4:0) x 16 ticks (0xE0 gives 512, 0xFF gives 1008).
- R5: A reference edge registered at clock k makes the active output inactive at clock k. The output for the new level (true output for high, complementary output for low) becomes active at the clock on which the L-th tick after clock k is counted, or at clock k itself when L is 0.
- R6: The two outputs are never active in the same cycle.
- R7: An edge of the reference that arrives while the dead time is still running reloads the count. The output that was waiting never becomes active.
- R8: A cycle with the tick enable low does not advance the dead-time count.
- R9: With the main output enable at 1 and the channel enabled, the output enable is 1 and the pin is the internal active state XOR the polarity bit (polarity 1 means active low).
- R10: With the main output enable at 1 and the channel disabled, the output enable is 0 and the pin sits at its inactive level, equal to the polarity bit.
- R11: With the main output enable at 0 and the off-state select at 0, both output enables are 0 and each pin shows its idle level.
- R12: With the main output enable at 0 and the off-state select at 1, each output enable equals its channel enable and each pin is forced to its idle level.
- R13: While reset is asserted, both internal outputs are inactive and the count is cleared. After reset the output matching the registered reference level (complementary for 0) becomes active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Dead-time clock enable, one tick per high cycle |
| ref_i | input | 1 | Reference PWM signal |
| dt_code_i | input | 8 | Dead-time code |
| en_a_i | input | 1 | True output channel enable |
| en_b_i | input | 1 | Complementary output channel enable |
| pol_a_i | input | 1 | True output polarity (1 = active low) |
| pol_b_i | input | 1 | Complementary output polarity (1 = active low) |
| idle_a_i | input | 1 | True output idle level |
| idle_b_i | input | 1 | Complementary output idle level |
| moe_i | input | 1 | Main output enable |
| ossi_i | input | 1 | Idle off-state select |
| pin_a_o | output | 1 | True output pin level |
| pin_b_o | output | 1 | Complementary output pin level |
| oe_a_o | output | 1 | True output pin enable |
| oe_b_o | output | 1 | Complementary output pin enable |

## Verification
The gap is measured in counted ticks for codes on both sides of every range boundary and for random codes. Rising and falling reference edges are both measured, which shows that the two ranges sharing a multiplier are decoded separately and that each edge direction has its own gap. Random, sparse tick patterns separate a count of clocks from a count of ticks. A reference pulse shorter than the dead time shows whether the counter reloads or lets the waiting output through. Random combinations of enables, polarities, idle levels and off-state controls are checked against the four output-stage rules.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
    localparam int CODE_W = 8;
    localparam int SCALE_MAX_SH = 4;
    localparam int CNT_W = CODE_W + 2;
    localparam int NCH = 2;

    typedef struct packed {
        logic             ref_s;
        logic [CNT_W-1:0] cnt;
        logic             act_a;
        logic             act_b;
    } dly_st_t;
endpackage

// File: rtl/cdt_decode.sv
module cdt_decode
    import cdt_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output logic [CNT_W-1:0]  len_o
);
    logic [CNT_W-1:0] base6_w;
    logic [CNT_W-1:0] base5_w;

    always_comb begin
        base6_w = {{(CNT_W-6){1'b0}}, code_i[5:0]} + CNT_W'(64);
        base5_w = {{(CNT_W-5){1'b0}}, code_i[4:0]} + CNT_W'(32);
        unique case (code_i[7:5])
            3'b100, 3'b101: len_o = base6_w << 1;
            3'b110:         len_o = base5_w << 3;
            3'b111:         len_o = base5_w << SCALE_MAX_SH;
            default:        len_o = {{(CNT_W-CODE_W){1'b0}}, code_i};
        endcase
    end
endmodule

// File: rtl/cdt_delay.sv
module cdt_delay
    import cdt_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             ref_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             act_a_o,
    output logic             act_b_o
);
    dly_st_t st_d, st_q;
    logic    edge_w;
    logic    last_w;

    always_comb begin
        st_d   = st_q;
        edge_w = ref_i ^ st_q.ref_s;
        last_w = (st_q.cnt == CNT_W'(1));
        if (edge_w) begin
            st_d.ref_s = ref_i;
            st_d.cnt   = len_i;
            st_d.act_a = (len_i == '0) && ref_i;
            st_d.act_b = (len_i == '0) && !ref_i;
        end else if (st_q.cnt != '0) begin
            if (tick_i) begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
                if (last_w) begin
                    st_d.act_a = st_q.ref_s;
                    st_d.act_b = !st_q.ref_s;
                end
            end
        end else begin
            st_d.act_a = st_q.ref_s;
            st_d.act_b = !st_q.ref_s;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_a_o = st_q.act_a;
    assign act_b_o = st_q.act_b;

    // R5
    edge_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (edge_w && len_i != '0) |=> (!st_q.act_a && !st_q.act_b));

    // R8
    tick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!edge_w && !tick_i && st_q.cnt != '0) |=> $stable(st_q.cnt));

    // R7
    wait_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.cnt > CNT_W'(1)) |-> (!st_q.act_a && !st_q.act_b));

    // R5
    release_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!edge_w && tick_i && last_w && st_q.ref_s) |=> st_q.act_a);
endmodule

// File: rtl/cdt_outstage.sv
module cdt_outstage (
    input  logic act_i,
    input  logic en_i,
    input  logic pol_i,
    input  logic idle_i,
    input  logic moe_i,
    input  logic ossi_i,
    output logic pin_o,
    output logic oe_o
);
    always_comb begin
        if (moe_i) begin
            oe_o  = en_i;
            pin_o = en_i ? (act_i ^ pol_i) : pol_i;
        end else begin
            oe_o  = ossi_i & en_i;
            pin_o = idle_i;
        end
    end
endmodule

// File: rtl/cdt_pair.sv
module cdt_pair
    import cdt_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              ref_i,
    input  logic [CODE_W-1:0] dt_code_i,
    input  logic              en_a_i,
    input  logic              en_b_i,
    input  logic              pol_a_i,
    input  logic              pol_b_i,
    input  logic              idle_a_i,
    input  logic              idle_b_i,
    input  logic              moe_i,
    input  logic              ossi_i,
    output logic              pin_a_o,
    output logic              pin_b_o,
    output logic              oe_a_o,
    output logic              oe_b_o
);
    logic [CNT_W-1:0] len_w;
    logic [NCH-1:0]   act_w;
    logic [NCH-1:0]   en_w;
    logic [NCH-1:0]   pol_w;
    logic [NCH-1:0]   idle_w;
    logic [NCH-1:0]   pin_w;
    logic [NCH-1:0]   oe_w;

    assign en_w   = {en_b_i, en_a_i};
    assign pol_w  = {pol_b_i, pol_a_i};
    assign idle_w = {idle_b_i, idle_a_i};

    cdt_decode u_dec (
        .code_i (dt_code_i),
        .len_o  (len_w)
    );

    cdt_delay u_dly (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tick_i  (tick_i),
        .ref_i   (ref_i),
        .len_i   (len_w),
        .act_a_o (act_w[0]),
        .act_b_o (act_w[1])
    );

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        cdt_outstage u_out (
            .act_i  (act_w[k]),
            .en_i   (en_w[k]),
            .pol_i  (pol_w[k]),
            .idle_i (idle_w[k]),
            .moe_i  (moe_i),
            .ossi_i (ossi_i),
            .pin_o  (pin_w[k]),
            .oe_o   (oe_w[k])
        );
    end

    assign pin_a_o = pin_w[0];
    assign pin_b_o = pin_w[1];
    assign oe_a_o  = oe_w[0];
    assign oe_b_o  = oe_w[1];

    // R6
    no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(act_w[0] && act_w[1]));

    // R11
    off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!moe_i && !ossi_i) |-> (!oe_a_o && !oe_b_o));

    // R4
    coarse_rng_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dt_code_i[7:5] == 3'b111) |-> (len_w[3:0] == 4'd0 && len_w >= CNT_W'(512)));

    // R1
    fine_rng_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!dt_code_i[7]) |-> (len_w < CNT_W'(128)));
endmodule

// File: tb/sim_cdt_pair.sv
`timescale 1ns/1ps
module sim_cdt_pair;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic       refs = 1'b0;
    logic [7:0] code = 8'd0;
    logic       en_a = 1'b1, en_b = 1'b1, pol_a = 1'b0, pol_b = 1'b0;
    logic       idle_a = 1'b0, idle_b = 1'b0, moe = 1'b1, ossi = 1'b0;
    logic       pin_a, pin_b, oe_a, oe_b;
    int         errors = 0;
    int         checks = 0;

    always #4 clk = ~clk;

    cdt_pair u0 (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .ref_i(refs), .dt_code_i(code),
        .en_a_i(en_a), .en_b_i(en_b), .pol_a_i(pol_a), .pol_b_i(pol_b),
        .idle_a_i(idle_a), .idle_b_i(idle_b), .moe_i(moe), .ossi_i(ossi),
        .pin_a_o(pin_a), .pin_b_o(pin_b), .oe_a_o(oe_a), .oe_b_o(oe_b)
    );

    function automatic int exp_len(input logic [7:0] c);
        if (!c[7])            return int'(c);
        else if (!c[6])       return (64 + int'(c[5:0])) * 2;
        else if (!c[5])       return (32 + int'(c[4:0])) * 8;
        else                  return (32 + int'(c[4:0])) * 16;
    endfunction

    function automatic string rng_tag(input logic [7:0] c);
        if (!c[7])      return "R1";
        else if (!c[6]) return "R2";
        else if (!c[5]) return "R3";
        else            return "R4";
    endfunction

    // {oe, pin} for one channel
    function automatic logic [1:0] exp_ch(input logic act, en, pol, idle, m, o);
        if (m) return {en, en ? (act ^ pol) : pol};
        return {o & en, idle};
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // drive a reference edge, count ticks until the new side activates
    task automatic meas(input logic nref, input int len, input bit sparse, input string tag);
        int  n = 0;
        bit  other_ok = 1'b1;
        bit  done = 1'b0;
        @(negedge clk);
        refs = nref;
        tick = sparse ? (($urandom % 3) == 0) : 1'b1;
        @(posedge clk);
        @(negedge clk);
        for (int g = 0; g < 4000 && !done; g++) begin
            if ((nref ? pin_b : pin_a) != 1'b0) other_ok = 1'b0;
            if (nref ? pin_a : pin_b) begin
                done = 1'b1;
            end else begin
                tick = sparse ? (($urandom % 3) == 0) : 1'b1;
                @(posedge clk);
                if (tick) n++;
                @(negedge clk);
            end
        end
        chk(done && n == len, tag, n, len);
        chk(other_ok, "R6", 0, 1);
        tick = 1'b1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] bnd [8];
        void'($urandom(32'd20240611));
        bnd = '{8'h00, 8'h7F, 8'h80, 8'hBF, 8'hC0, 8'hDF, 8'hE0, 8'hFF};

        // R13 reset state
        repeat (3) @(negedge clk);
        chk(pin_a == 1'b0 && pin_b == 1'b0, "R13 reset", {pin_a, pin_b}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pin_a == 1'b0 && pin_b == 1'b1, "R13 after reset", {pin_a, pin_b}, 1);

        // R1..R4 boundaries, both edge directions
        foreach (bnd[i]) begin
            code = bnd[i];
            meas(1'b1, exp_len(bnd[i]), 1'b0, rng_tag(bnd[i]));
            meas(1'b0, exp_len(bnd[i]), 1'b0, {rng_tag(bnd[i]), " R5 fall"});
        end

        // random codes, dense ticks
        for (int i = 0; i < 12; i++) begin
            code = 8'($urandom);
            meas(1'b1, exp_len(code), 1'b0, rng_tag(code));
            meas(1'b0, exp_len(code), 1'b0, "R5");
        end

        // R8 sparse random ticks
        for (int i = 0; i < 16; i++) begin
            code = 8'($urandom % 192);
            meas(1'b1, exp_len(code), 1'b1, "R8");
            meas(1'b0, exp_len(code), 1'b1, "R8");
        end

        // R7 short pulse: waiting true output never activates
        code = 8'd20;
        @(negedge clk);
        refs = 1'b1;
        repeat (6) @(negedge clk);
        chk(pin_a == 1'b0 && pin_b == 1'b0, "R7 waiting", {pin_a, pin_b}, 0);
        meas(1'b0, 20, 1'b0, "R7 reload");
        repeat (30) @(negedge clk);
        chk(pin_a == 1'b0 && pin_b == 1'b1, "R7 settled", {pin_a, pin_b}, 1);

        // output stage, internal state: true output active after this
        code = 8'd3;
        meas(1'b1, 3, 1'b0, "R5");
        for (int i = 0; i < 60; i++) begin
            logic [1:0] ea, eb;
            string      t;
            @(negedge clk);
            {en_a, en_b, pol_a, pol_b, idle_a, idle_b, moe, ossi} = 8'($urandom);
            #1;
            ea = exp_ch(1'b1, en_a, pol_a, idle_a, moe, ossi);
            eb = exp_ch(1'b0, en_b, pol_b, idle_b, moe, ossi);
            if (moe) t = "R9/R10";
            else if (ossi) t = "R12";
            else t = "R11";
            chk({oe_a, pin_a} == ea, {t, " a"}, {oe_a, pin_a}, ea);
            chk({oe_b, pin_b} == eb, {t, " b"}, {oe_b, pin_b}, eb);
        end

        // R10 directed: disabled channel at its inactive level
        @(negedge clk);
        {moe, en_a, en_b, pol_a, pol_b} = 5'b1_0_0_1_0;
        #1;
        chk(oe_a == 0 && pin_a == 1 && oe_b == 0 && pin_b == 0, "R10",
            {oe_a, pin_a, oe_b, pin_b}, 4'b0100);

        // R12 directed
        @(negedge clk);
        {moe, ossi, en_a, en_b, idle_a, idle_b} = 6'b0_1_1_0_1_1;
        #1;
        chk(oe_a == 1 && pin_a == 1 && oe_b == 0 && pin_b == 1, "R12",
            {oe_a, pin_a, oe_b, pin_b}, 4'b1101);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule